// File: doc/BRIEF.md
# Priority Interrupt Level Group

This block manages a group of priority interrupt levels, sixteen by default. Each level is held in one of four states: disarmed, armed, waiting or active. Each level also has an enable bit. Rising edges on the external request lines move armed levels to waiting. The CPU can also trigger any set of levels through a masked control command, with the same result as an external edge. The block presents the most urgent serviceable level on `irq` and `irq_lvl`.

An acknowledge strobe moves the presented level to active. The routine-exit strobe returns the most urgent active level to armed. Disarming a level throws away any request it receives. Disabling a level keeps a latched request but holds back its service until the level is enabled again.

Every level state and enable bit can be read on status outputs. All of them can be written back in a single cycle through a load strobe, so a saved interrupt context can be restored exactly.

Top module: `prio_irq_group`

## Requirements
- R1: After reset every level is disarmed and disabled, `st_out` and `en_out` read zero and `irq` is low.
- R2: Control codes act on the levels selected by `ctl_mask` when `ctl_valid` is high. Code 1 (arm) moves disarmed levels to armed and leaves other states unchanged. Code 2 (disarm) forces levels to disarmed from any state, and it overrides every other event on that level in the same cycle.
- R3: Code 3 sets the enable bit of the selected levels and code 4 clears it. Neither code changes any level state.
- R4: A rising edge on `req_in[i]` moves level i from armed to waiting. A line held high latches only once. An edge on a disarmed level is discarded, and the request is not recalled when the level is armed later.
- R5: Code 5 (trigger) has the same effect on the selected levels as a rising request edge.
- R6: `irq` is high and `irq_lvl` names the lowest-numbered level that is waiting, enabled, and numbered below every active level (level 0 is most urgent). A disabled waiting level stays waiting and is presented once it is enabled again.
- R7: `ack_in` while `irq` is high makes the presented level active at the next edge. `ack_in` while `irq` is low changes nothing.
- R8: `clr_act` returns the lowest-numbered active level to armed. It changes nothing when no level is active, and it acts on the state from before any acknowledge in the same cycle.
- R9: `st_out[2i+1:2i]` gives level i's state: 0 disarmed, 1 armed, 2 waiting, 3 active. `en_out[i]` gives level i's enable bit. `ld_valid` replaces all states and enables with `ld_state` and `ld_en`, and it takes precedence over every other event in that cycle.
- R10: Requests and triggers that reach a level which is already waiting or active are ignored. Requests do not stack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | NLVL | External request lines, rising-edge sensitive |
| ctl_valid | input | 1 | Control command strobe |
| ctl_op | input | 3 | Control code: 1 arm, 2 disarm, 3 enable, 4 disable, 5 trigger |
| ctl_mask | input | NLVL | Levels the control command applies to |
| ack_in | input | 1 | CPU acknowledge of the presented level |
| clr_act | input | 1 | Routine exit, clears the most urgent active level |
| ld_valid | input | 1 | Restore strobe |
| ld_state | input | 2*NLVL | States to restore, two bits per level |
| ld_en | input | NLVL | Enable bits to restore |
| irq | output | 1 | A level is ready for service |
| irq_lvl | output | LW | Number of the presented level |
| st_out | output | 2*NLVL | State of every level, two bits per level |
| en_out | output | NLVL | Enable bit of every level |

## Verification
The bench builds the block with its default NLVL of 16, which is one full group. This size puts both extreme levels, 0 and 15, within reach. It also makes the priority blocking by an active level visible both above and below the blocking level. The stimulus table combines acknowledge with routine exit, and acknowledge with disarm, in the same cycle. Directed steps then save the full status and restore it through the load port, and they check that requests to an active level are ignored.

// File: rtl/prio_irq_group.sv
module prio_irq_group #(
  parameter int NLVL = 16,
  localparam int LW = (NLVL > 1) ? $clog2(NLVL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLVL-1:0]   req_in,
  input  logic              ctl_valid,
  input  logic [2:0]        ctl_op,
  input  logic [NLVL-1:0]   ctl_mask,
  input  logic              ack_in,
  input  logic              clr_act,
  input  logic              ld_valid,
  input  logic [2*NLVL-1:0] ld_state,
  input  logic [NLVL-1:0]   ld_en,
  output logic              irq,
  output logic [LW-1:0]     irq_lvl,
  output logic [2*NLVL-1:0] st_out,
  output logic [NLVL-1:0]   en_out
);
  localparam logic [1:0] S_DIS = 2'd0, S_ARM = 2'd1, S_WAIT = 2'd2, S_ACT = 2'd3;
  localparam logic [2:0] OP_ARM = 3'd1, OP_DISARM = 3'd2, OP_EN = 3'd3, OP_DSB = 3'd4, OP_TRG = 3'd5;

  logic [1:0] st [NLVL];
  logic [1:0] st_nx [NLVL];
  logic [NLVL-1:0] en, en_nx, req_q, rise;
  logic [NLVL-1:0] v_dis, v_wait, v_act;
  logic [NLVL-1:0] arm_m, dis_m, ena_m, dsb_m, trg_m;
  logic act_any, found, blocked;
  logic [LW-1:0] act_top, pick;

  assign rise  = req_in & ~req_q;
  assign arm_m = (ctl_valid && ctl_op == OP_ARM)    ? ctl_mask : '0;
  assign dis_m = (ctl_valid && ctl_op == OP_DISARM) ? ctl_mask : '0;
  assign ena_m = (ctl_valid && ctl_op == OP_EN)     ? ctl_mask : '0;
  assign dsb_m = (ctl_valid && ctl_op == OP_DSB)    ? ctl_mask : '0;
  assign trg_m = (ctl_valid && ctl_op == OP_TRG)    ? ctl_mask : '0;

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    assign st_out[2*g +: 2] = st[g];
    assign v_dis[g]  = (st[g] == S_DIS);
    assign v_wait[g] = (st[g] == S_WAIT);
    assign v_act[g]  = (st[g] == S_ACT);
  end
  assign en_out = en;

  always_comb begin
    act_any = 1'b0;
    act_top = '0;
    found   = 1'b0;
    blocked = 1'b0;
    pick    = '0;
    for (int i = 0; i < NLVL; i++) begin
      if (!found && !blocked && v_wait[i] && en[i]) begin
        found = 1'b1;
        pick  = LW'(i);
      end
      if (v_act[i] && !act_any) begin
        act_any = 1'b1;
        act_top = LW'(i);
      end
      if (v_act[i]) blocked = 1'b1;
    end
  end

  assign irq     = found;
  assign irq_lvl = pick;

  always_comb begin
    for (int i = 0; i < NLVL; i++) begin
      st_nx[i] = st[i];
      en_nx[i] = en[i];
      if ((rise[i] || trg_m[i]) && st[i] == S_ARM) st_nx[i] = S_WAIT;
      if (ack_in && found && pick == LW'(i)) st_nx[i] = S_ACT;
      if (clr_act && act_any && act_top == LW'(i)) st_nx[i] = S_ARM;
      if (arm_m[i] && st[i] == S_DIS) st_nx[i] = S_ARM;
      if (dis_m[i]) st_nx[i] = S_DIS;
      if (ena_m[i]) en_nx[i] = 1'b1;
      if (dsb_m[i]) en_nx[i] = 1'b0;
      if (ld_valid) begin
        st_nx[i] = ld_state[2*i +: 2];
        en_nx[i] = ld_en[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= '0;
      en    <= '0;
      for (int i = 0; i < NLVL; i++) st[i] <= S_DIS;
    end else begin
      req_q <= req_in;
      en    <= en_nx;
      for (int i = 0; i < NLVL; i++) st[i] <= st_nx[i];
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (st_out == '0 && en_out == '0 && !irq));

  assert_disarm_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_op == OP_DISARM && !ld_valid) |=> ((v_dis & $past(ctl_mask)) == $past(ctl_mask)));

  assert_enable_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_valid && ctl_op == OP_EN && !ld_valid) |=> ((en_out & $past(ctl_mask)) == $past(ctl_mask)));

  assert_disarmed_drops_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> (($past(v_dis) & (v_wait | v_act)) == '0));

  assert_present_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (v_wait[irq_lvl] && en_out[irq_lvl] && (!act_any || irq_lvl < act_top)));

  assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_in && irq && !ld_valid && !dis_m[irq_lvl]) |=> v_act[$past(irq_lvl)]);

  assert_clear_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_act && act_any && !ld_valid) |=> !v_act[$past(act_top)]);

  assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> (st_out == $past(ld_state) && en_out == $past(ld_en)));
endmodule

// File: tb/sim_prio_irq_group.sv
module sim_prio_irq_group;
  localparam int N = 16;
  localparam int LW = 4;
  localparam int NV = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req_in = '0;
  logic ctl_valid = 1'b0;
  logic [2:0] ctl_op = '0;
  logic [N-1:0] ctl_mask = '0;
  logic ack_in = 1'b0, clr_act = 1'b0, ld_valid = 1'b0;
  logic [2*N-1:0] ld_state = '0;
  logic [N-1:0] ld_en = '0;
  logic irq;
  logic [LW-1:0] irq_lvl;
  logic [2*N-1:0] st_out;
  logic [N-1:0] en_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_group #(.NLVL(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .ctl_valid(ctl_valid), .ctl_op(ctl_op),
    .ctl_mask(ctl_mask), .ack_in(ack_in), .clr_act(clr_act), .ld_valid(ld_valid),
    .ld_state(ld_state), .ld_en(ld_en), .irq(irq), .irq_lvl(irq_lvl),
    .st_out(st_out), .en_out(en_out));

  // {op, mask, req, ack, clr, exp_irq, exp_lvl}
  localparam logic [41:0] TBL [NV] = '{
    {3'd1, 16'h00FF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},  // R2 arm 0-7
    {3'd3, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},  // R3 enable all
    {3'd0, 16'h0000, 16'h0010, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 edge lvl4
    {3'd0, 16'h0000, 16'h0010, 1'b0, 1'b0, 1'b1, 4'd4},  // R4 held line
    {3'd0, 16'h0000, 16'h0010, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 ack lvl4
    {3'd0, 16'h0000, 16'h0020, 1'b0, 1'b0, 1'b0, 4'd0},  // R6 lvl5 blocked by active 4
    {3'd0, 16'h0000, 16'h0024, 1'b0, 1'b0, 1'b1, 4'd2},  // R6 lvl2 above active
    {3'd0, 16'h0000, 16'h0024, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 ack lvl2
    {3'd0, 16'h0000, 16'h0024, 1'b0, 1'b1, 1'b0, 4'd0},  // R8 clear lvl2
    {3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 4'd5},  // R8 clear lvl4
    {3'd4, 16'h0020, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},  // R6 disabled held back
    {3'd3, 16'h0020, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd5},  // R6 re-enabled
    {3'd5, 16'h0009, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd0},  // R5 trigger 0 and 3
    {3'd2, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd3},  // R2 disarm lvl0
    {3'd0, 16'h0000, 16'h0101, 1'b0, 1'b0, 1'b1, 4'd3},  // R4 edges on disarmed
    {3'd1, 16'h0101, 16'h0101, 1'b0, 1'b0, 1'b1, 4'd3},  // R4 arm, no recall
    {3'd0, 16'h0000, 16'h0101, 1'b1, 1'b0, 1'b0, 4'd0},  // R7 ack lvl3
    {3'd5, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd0},  // R5 trigger lvl0
    {3'd0, 16'h0000, 16'h0000, 1'b1, 1'b1, 1'b0, 4'd0},  // R8 ack 0 and clear 3
    {3'd0, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b1, 4'd5},  // R8 clear lvl0
    {3'd2, 16'h0020, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0},  // R2 disarm beats ack
    {3'd5, 16'h8000, 16'h0000, 1'b1, 1'b0, 1'b0, 4'd0},  // R5 trigger disarmed, R7 idle ack
    {3'd1, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b0, 4'd0},  // R4 arm lvl15, nothing kept
    {3'd5, 16'h8000, 16'h0000, 1'b0, 1'b0, 1'b1, 4'd15}  // R5 trigger lvl15
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] op, input logic [N-1:0] mask, input logic [N-1:0] req,
                       input logic ack, input logic clr);
    ctl_valid = (op != 3'd0);
    ctl_op = op;
    ctl_mask = mask;
    req_in = req;
    ack_in = ack;
    clr_act = clr;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    logic [2*N-1:0] saved_st;
    logic [N-1:0] saved_en;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st_out == '0 && en_out == '0 && !irq, "R1 reset state", {st_out, en_out, 15'd0, irq}, 64'd0);

    for (int k = 0; k < NV; k++) begin
      drive(TBL[k][41:39], TBL[k][38:23], TBL[k][22:7], TBL[k][6], TBL[k][5]);
      @(negedge clk);
      chk(irq == TBL[k][4] && (!irq || irq_lvl == TBL[k][3:0]),
          $sformatf("R6 table step %0d irq/lvl", k), {irq, irq_lvl}, {TBL[k][4], TBL[k][3:0]});
    end
    drive(3'd0, '0, '0, 1'b0, 1'b0);
    @(negedge clk);

    chk(st_out[31:30] == 2'd2, "R5 lvl15 waiting", st_out[31:30], 2'd2);
    chk(st_out[11:10] == 2'd0, "R2 lvl5 disarmed", st_out[11:10], 2'd0);
    chk(st_out[17:16] == 2'd1, "R4 lvl8 armed only", st_out[17:16], 2'd1);

    // R9 save, clear, restore
    saved_st = st_out;
    saved_en = en_out;
    ld_valid = 1'b1; ld_state = '0; ld_en = '0;
    ack_in = 1'b1;
    @(negedge clk);
    chk(st_out == '0 && en_out == '0 && !irq, "R9 load zeros", {st_out, en_out}, 48'd0);
    ld_state = saved_st; ld_en = saved_en; ack_in = 1'b0;
    @(negedge clk);
    ld_valid = 1'b0;
    chk(st_out == saved_st && en_out == saved_en, "R9 restore state", {st_out, en_out}, {saved_st, saved_en});
    chk(irq && irq_lvl == 4'd15, "R9 restored presentation", {irq, irq_lvl}, {1'b1, 4'd15});

    // R10 trigger and edge to an active level
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    drive(3'd5, 16'h8000, 16'h8000, 1'b0, 1'b0);
    @(negedge clk);
    drive(3'd0, '0, '0, 1'b0, 1'b0);
    chk(st_out[31:30] == 2'd3 && !irq, "R10 active ignores request", {irq, st_out[31:30]}, {1'b0, 2'd3});

    // R7 ack with irq low
    saved_st = st_out;
    ack_in = 1'b1;
    @(negedge clk);
    ack_in = 1'b0;
    chk(st_out == saved_st, "R7 idle ack no effect", st_out, saved_st);

    // R3 disable leaves states
    drive(3'd4, 16'hFFFF, '0, 1'b0, 1'b0);
    @(negedge clk);
    drive(3'd0, '0, '0, 1'b0, 1'b0);
    chk(en_out == '0 && st_out == saved_st, "R3 disable keeps states", {st_out, en_out}, {saved_st, 16'h0});

    // R8 clear with none active after clearing lvl15
    clr_act = 1'b1;
    @(negedge clk);
    chk(st_out[31:30] == 2'd1, "R8 clear lvl15", st_out[31:30], 2'd1);
    saved_st = st_out;
    @(negedge clk);
    clr_act = 1'b0;
    chk(st_out == saved_st, "R8 clear with none active", st_out, saved_st);

    report();
  end
endmodule